// File: doc/BRIEF.md
# Configurable Serial Audio Receiver (two-slot stereo / eight-slot multi-sample)

This block turns a serial audio stream (bit clock, word strobe and data line) into parallel sample words. The three serial inputs are brought into the system clock domain by a short synchronizer chain. Every rising edge of the bit clock becomes a one-cycle bit tick, and the data line is shifted in MSB first on each tick.

A set of static configuration inputs selects the frame format. In two-slot framing, each change of the strobe starts a new slot, and the strobe level tells left from right. In multi-sample framing, a strobe edge into the left level starts a frame of eight fixed 32-bit slots. Other settings choose left- or right-justified words, the strobe level that means left, and whether the strobe moves with the first bit of a slot or one bit earlier. In multi-sample framing a four-bit code sets the word length. A shared-timing input overrides justification and polarity. A drive flag is passed to the output enables of the clock and strobe pads, so an external master can drive those pins when the flag is clear.

Each completed word appears on the parallel output, right-justified, with its slot index and a single-cycle valid strobe.

Top module: `i2s_rx`

## Requirements
- R1: Data bits are taken MSB first on each rising bit-clock edge. A word of N bits is presented in the low N bits of `smp_data`, and every higher bit is 0.
- R2: Each word produces exactly one system-clock cycle of `smp_valid`, together with its slot index. The strobe is visible after the third rising system-clock edge that follows the bit-clock rise completing the word.
- R3: With `cfg_align_right`=0, the word is the first N bits of the slot. It is reported on the tick of the slot's Nth bit.
- R4: With `cfg_align_right`=1, the word is the last N bits before the next slot starts. It is reported on the tick of the next slot's first bit.
- R5: With `cfg_ws_left_high`=1, strobe high marks the left channel (slot 0). With it at 0, strobe low marks the left channel.
- R6: With `cfg_ws_early`=0, the strobe changes level together with the first bit of a slot. With it at 1, the strobe changes one bit earlier.
- R7: With `cfg_multi`=0, every strobe change starts a slot: the left level gives slot 0 and the right level gives slot 1. Slots are 18 to 32 bits long, the word length is 18, and `cfg_len_code` has no effect.
- R8: With `cfg_multi`=1, only a strobe edge into the left level starts a frame at slot 0. The following slots 1 to 7 begin every 32 bits, and a strobe edge into the right level has no effect.
- R9: In multi-sample framing, length codes 7 to 15 give N = 2*(code+1) bits (16 to 32). Codes 0 to 6 are treated as 16 bits.
- R10: With `cfg_shared_timing`=1, justification and polarity behave as 0, whatever `cfg_align_right` and `cfg_ws_left_high` hold.
- R11: `pin_sck_oe` and `pin_ws_oe` follow `cfg_pin_drive`: 1 drives the pads, 0 leaves them high impedance.
- R12: While reset is asserted, and after it, no word is reported until a slot start has been seen. Reset clears `smp_data`, `smp_slot` and `smp_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i2s_sck | input | 1 | Serial bit clock |
| i2s_ws | input | 1 | Word strobe |
| i2s_sd | input | 1 | Serial data |
| cfg_align_right | input | 1 | 0 left-justified, 1 right-justified |
| cfg_ws_left_high | input | 1 | 1: strobe high means left |
| cfg_ws_early | input | 1 | 1: strobe leads the slot by one bit |
| cfg_multi | input | 1 | 0 two-slot, 1 eight-slot framing |
| cfg_len_code | input | 4 | Word length code (multi-sample framing) |
| cfg_shared_timing | input | 1 | Forces justification and polarity to 0 |
| cfg_pin_drive | input | 1 | Pad drive flag for clock and strobe |
| pin_sck_oe | output | 1 | Bit-clock pad output enable |
| pin_ws_oe | output | 1 | Strobe pad output enable |
| smp_data | output | 32 | Received word, right-justified |
| smp_slot | output | 3 | Slot index of the word |
| smp_valid | output | 1 | One-cycle word strobe |

## Verification
A word's strobe comes three system-clock edges after the bit-clock rise that completes it: two synchronizer stages, then the capture register. The bench drives the bit clock on falling system-clock edges and records the cycle count at each rise. The monitor samples on falling edges and checks that each valid strobe lands exactly three counts later and lasts one cycle. Justification and framing decide which bit tick completes a word: the Nth bit of the slot for left-justified data, and the first bit of the next slot for right-justified data. The bench therefore ends every stream with two bits of a new frame, so that it can compare a full, ordered list of words against the values it computed for each configuration.

// File: rtl/i2srx_pkg.sv
package i2srx_pkg;
    localparam int unsigned WORD_W      = 32;
    localparam int unsigned SLOT_BITS   = 32;
    localparam int unsigned CNT_W       = $clog2(SLOT_BITS);
    localparam int unsigned MULTI_SLOTS = 8;
    localparam int unsigned SLOT_W      = $clog2(MULTI_SLOTS);
    localparam int unsigned LEN_W       = $clog2(WORD_W) + 1;
    localparam int unsigned CODE_W      = 4;
    localparam int unsigned TWO_LEN     = 18;
    localparam int unsigned CODE_FLOOR  = 7;

    // Word length in bits for the selected framing and code.
    function automatic logic [LEN_W-1:0] word_len(input logic multi,
                                                  input logic [CODE_W-1:0] code);
        if (!multi) return LEN_W'(TWO_LEN);
        if (code < CODE_W'(CODE_FLOOR)) return LEN_W'(2 * (CODE_FLOOR + 1));
        return LEN_W'({code, 1'b0}) + LEN_W'(2);
    endfunction

    // Low-order mask of n ones.
    function automatic logic [WORD_W-1:0] len_mask(input logic [LEN_W-1:0] n);
        return {WORD_W{1'b1}} >> (LEN_W'(WORD_W) - n);
    endfunction
endpackage

// File: rtl/i2srx_sync.sv
module i2srx_sync #(
    parameter int unsigned W      = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                assign stg_d[g] = din;
            end else begin : g_next
                assign stg_d[g] = stg_q[g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        for (int k = 0; k < STAGES; k++) begin
            if (!rst_n) stg_q[k] <= '0;
            else        stg_q[k] <= stg_d[k];
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/i2srx_framer.sv
module i2srx_framer
    import i2srx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              ws,
    input  logic              multi,
    input  logic              early,
    input  logic              pol,
    output logic              cur_start,
    output logic              cur_active,
    output logic [CNT_W-1:0]  cur_cnt,
    output logic [SLOT_W-1:0] cur_slot,
    output logic              prev_active,
    output logic [SLOT_W-1:0] prev_slot
);
    typedef struct packed {
        logic              ws_prev;
        logic              seen;
        logic              pending;
        logic [SLOT_W-1:0] pend_slot;
        logic [CNT_W-1:0]  cnt;
        logic [SLOT_W-1:0] slot;
        logic              active;
    } frm_t;

    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SLOT_BITS - 1);

    frm_t              st_d, st_q;
    logic              left, change, evt, start;
    logic [SLOT_W-1:0] evt_slot, new_slot;

    always_comb begin
        st_d     = st_q;
        left     = (ws == pol);
        change   = st_q.seen && (ws != st_q.ws_prev);
        evt      = multi ? (change && left) : change;
        evt_slot = (multi || left) ? '0 : SLOT_W'(1);
        start    = early ? st_q.pending   : evt;
        new_slot = early ? st_q.pend_slot : evt_slot;
        if (!start && multi && st_q.active && st_q.cnt == CNT_LAST) begin
            start    = 1'b1;
            new_slot = st_q.slot + SLOT_W'(1);
        end
        cur_start  = tick && start;
        cur_active = start || st_q.active;
        cur_slot   = start ? new_slot : st_q.slot;
        if (start)                     cur_cnt = '0;
        else if (st_q.cnt == CNT_LAST) cur_cnt = st_q.cnt;
        else                           cur_cnt = st_q.cnt + CNT_W'(1);
        if (tick) begin
            st_d.ws_prev   = ws;
            st_d.seen      = 1'b1;
            st_d.pending   = early && evt;
            st_d.pend_slot = evt_slot;
            st_d.cnt       = cur_cnt;
            st_d.slot      = cur_slot;
            st_d.active    = cur_active;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign prev_active = st_q.active;
    assign prev_slot   = st_q.slot;

    // R8: after the last bit of a 32-bit slot the next tick begins a slot
    a_r8_slot_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && multi && st_q.active && st_q.cnt == CNT_LAST) |=> (st_q.cnt == '0));

    // R7: two-slot framing only ever reaches slot 0 or 1
    a_r7_two_slots: assert property (@(posedge clk) disable iff (!rst_n)
        (!multi && $past(!multi)) |-> (st_q.slot <= SLOT_W'(1)));
endmodule

// File: rtl/i2srx_capture.sv
module i2srx_capture
    import i2srx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              sd,
    input  logic              align_right,
    input  logic [LEN_W-1:0]  n_len,
    input  logic              cur_start,
    input  logic              cur_active,
    input  logic [CNT_W-1:0]  cur_cnt,
    input  logic [SLOT_W-1:0] cur_slot,
    input  logic              prev_active,
    input  logic [SLOT_W-1:0] prev_slot,
    output logic [WORD_W-1:0] data,
    output logic [SLOT_W-1:0] slot,
    output logic              valid
);
    typedef struct packed {
        logic [WORD_W-1:0] sh;
        logic [WORD_W-1:0] data;
        logic [SLOT_W-1:0] slot;
        logic              valid;
    } cap_t;

    cap_t              st_d, st_q;
    logic [WORD_W-1:0] sh_new, mask;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        mask       = len_mask(n_len);
        sh_new     = {st_q.sh[WORD_W-2:0], sd};
        if (tick) begin
            st_d.sh = sh_new;
            if (align_right) begin
                if (cur_start && prev_active) begin
                    st_d.data  = st_q.sh & mask;
                    st_d.slot  = prev_slot;
                    st_d.valid = 1'b1;
                end
            end else if (cur_active && ({1'b0, cur_cnt} == n_len - LEN_W'(1))) begin
                st_d.data  = sh_new & mask;
                st_d.slot  = cur_slot;
                st_d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data  = st_q.data;
    assign slot  = st_q.slot;
    assign valid = st_q.valid;

    // R2: valid lasts one cycle
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid |=> !st_q.valid);

    // R2: a word only follows a bit tick
    a_r2_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid |-> $past(tick));

    // R1: bits above the word length are zero
    a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.valid && $stable(n_len)) |-> ((st_q.data & ~len_mask(n_len)) == '0));
endmodule

// File: rtl/i2s_rx.sv
module i2s_rx
    import i2srx_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        i2s_sck,
    input  logic        i2s_ws,
    input  logic        i2s_sd,
    input  logic        cfg_align_right,
    input  logic        cfg_ws_left_high,
    input  logic        cfg_ws_early,
    input  logic        cfg_multi,
    input  logic [3:0]  cfg_len_code,
    input  logic        cfg_shared_timing,
    input  logic        cfg_pin_drive,
    output logic        pin_sck_oe,
    output logic        pin_ws_oe,
    output logic [31:0] smp_data,
    output logic [2:0]  smp_slot,
    output logic        smp_valid
);
    logic [2:0]        pins_s;
    logic              sck_s, ws_s, sd_s, tick;
    logic              sck_prev_d, sck_prev_q;
    logic              align_eff, pol_eff;
    logic [LEN_W-1:0]  n_len;
    logic              f_start, f_active, f_prev_active;
    logic [CNT_W-1:0]  f_cnt;
    logic [SLOT_W-1:0] f_slot, f_prev_slot;

    i2srx_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({i2s_sck, i2s_ws, i2s_sd}),
        .dout (pins_s)
    );

    assign {sck_s, ws_s, sd_s} = pins_s;

    always_comb sck_prev_d = sck_s;

    always_ff @(posedge clk) begin
        if (!rst_n) sck_prev_q <= 1'b0;
        else        sck_prev_q <= sck_prev_d;
    end

    assign tick       = sck_s && !sck_prev_q;
    assign align_eff  = cfg_align_right  && !cfg_shared_timing;
    assign pol_eff    = cfg_ws_left_high && !cfg_shared_timing;
    assign n_len      = word_len(cfg_multi, cfg_len_code);
    assign pin_sck_oe = cfg_pin_drive;
    assign pin_ws_oe  = cfg_pin_drive;

    i2srx_framer u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .ws         (ws_s),
        .multi      (cfg_multi),
        .early      (cfg_ws_early),
        .pol        (pol_eff),
        .cur_start  (f_start),
        .cur_active (f_active),
        .cur_cnt    (f_cnt),
        .cur_slot   (f_slot),
        .prev_active(f_prev_active),
        .prev_slot  (f_prev_slot)
    );

    i2srx_capture u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .sd         (sd_s),
        .align_right(align_eff),
        .n_len      (n_len),
        .cur_start  (f_start),
        .cur_active (f_active),
        .cur_cnt    (f_cnt),
        .cur_slot   (f_slot),
        .prev_active(f_prev_active),
        .prev_slot  (f_prev_slot),
        .data       (smp_data),
        .slot       (smp_slot),
        .valid      (smp_valid)
    );
endmodule

// File: tb/tb_i2s_rx.sv
module tb_i2s_rx;
    localparam int CLK_PERIOD = 10;
    localparam int PRE        = 4;
    localparam int POST       = 2;
    localparam int WATCHDOG   = 200000;

    logic        clk = 0, rst_n = 0;
    logic        i2s_sck = 0, i2s_ws = 0, i2s_sd = 0;
    logic        cfg_align_right = 0, cfg_ws_left_high = 0, cfg_ws_early = 0;
    logic        cfg_multi = 0, cfg_shared_timing = 0, cfg_pin_drive = 0;
    logic [3:0]  cfg_len_code = 0;
    logic        pin_sck_oe, pin_ws_oe, smp_valid;
    logic [31:0] smp_data;
    logic [2:0]  smp_slot;

    i2s_rx dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int          cyc = 0, rise_cyc = 0, checks = 0, fails = 0;
    bit          prev_valid = 0;
    logic [31:0] got_d[$], exp_d[$];
    logic [2:0]  got_s[$], exp_s[$];

    always @(posedge clk) cyc++;

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // R2: latency and pulse width of each word strobe
    always @(negedge clk) begin
        if (rst_n && smp_valid) begin
            got_d.push_back(smp_data);
            got_s.push_back(smp_slot);
            check(cyc == rise_cyc + 3, "R2 latency", 32'(cyc - rise_cyc), 32'd3);
            check(!prev_valid, "R2 one-cycle strobe", 32'(prev_valid), 32'd0);
        end
        prev_valid = smp_valid;
    end

    function automatic logic [31:0] bmask(input int n);
        return (n >= 32) ? 32'hFFFF_FFFF : 32'((64'd1 << n) - 64'd1);
    endfunction

    function automatic logic [31:0] wordval(input int cfgn, input int fr, input int s,
                                            input int n);
        logic [31:0] v = 32'(cfgn * 37 + s * 11 + fr * 5 + 1) * 32'h9E37_79B1;
        return v & bmask(n);
    endfunction

    // -1 idle, otherwise the slot the bit belongs to (trailing bits: slot 0)
    function automatic int kind_of(input int b, input int sl, input int len, input int frames);
        if (b < PRE) return -1;
        if (b - PRE >= frames * sl * len) return 0;
        return ((b - PRE) / len) % sl;
    endfunction

    function automatic logic sd_of(input int b, input int sl, input int len, input int frames,
                                   input bit align, input int n, input int cfgn);
        int idx, fr, s, p;
        logic [31:0] w;
        if (b < PRE) return 1'b1;
        idx = b - PRE;
        if (idx >= frames * sl * len) return 1'b0;
        fr = idx / (sl * len);
        s  = (idx / len) % sl;
        p  = idx % len;
        w  = wordval(cfgn, fr, s, n);
        if (!align) return (p < n) ? w[n-1-p] : 1'b1;
        return (p >= len - n) ? w[len-1-p] : 1'b1;
    endfunction

    task automatic run_cfg(input bit multi, input bit align_in, input bit pol_in,
                           input bit early, input int code, input bit shared,
                           input int slen, input int frames, input int cfgn);
        bit    align = align_in && !shared;
        bit    pol   = pol_in && !shared;
        int    n     = multi ? ((code < 7) ? 16 : 2 * (code + 1)) : 18;
        int    sl    = multi ? 8 : 2;
        int    len   = multi ? 32 : slen;
        int    nbits = PRE + frames * sl * len + POST;
        string tag;
        tag = $sformatf("R1 %s %s R5 R6%s cfg%0d", align ? "R4" : "R3",
                        multi ? "R8 R9" : "R7", shared ? " R10" : "", cfgn);
        @(negedge clk);
        rst_n = 0; i2s_sck = 0; i2s_sd = 0; i2s_ws = !pol;
        cfg_multi = multi; cfg_align_right = align_in; cfg_ws_left_high = pol_in;
        cfg_ws_early = early; cfg_len_code = 4'(code); cfg_shared_timing = shared;
        repeat (3) @(negedge clk);
        rst_n = 1;
        got_d.delete(); got_s.delete(); exp_d.delete(); exp_s.delete();
        for (int fr = 0; fr < frames; fr++)
            for (int s = 0; s < sl; s++) begin
                exp_d.push_back(wordval(cfgn, fr, s, n));
                exp_s.push_back(3'(s));
            end
        for (int b = 0; b < nbits; b++) begin
            int k = kind_of(b + (early ? 1 : 0), sl, len, frames);
            i2s_sck = 0;
            i2s_ws  = (k == 0) ? pol : !pol;
            i2s_sd  = sd_of(b, sl, len, frames, align, n, cfgn);
            @(negedge clk);
            @(negedge clk);
            i2s_sck  = 1;
            rise_cyc = cyc;
            @(negedge clk);
            @(negedge clk);
        end
        i2s_sck = 0;
        repeat (8) @(negedge clk);
        check(got_d.size() == exp_d.size(), {"R12 word count ", tag},
              32'(got_d.size()), 32'(exp_d.size()));
        for (int i = 0; i < exp_d.size() && i < got_d.size(); i++) begin
            check(got_d[i] == exp_d[i], {"data ", tag}, got_d[i], exp_d[i]);
            check(got_s[i] == exp_s[i], {"slot ", tag}, 32'(got_s[i]), 32'(exp_s[i]));
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int cfgn = 0;
        int codes[5] = '{3, 7, 8, 12, 15};
        repeat (4) @(negedge clk);
        check(smp_valid == 0, "R12 reset valid", 32'(smp_valid), 32'd0);
        check(smp_data == 0, "R12 reset data", smp_data, 32'd0);
        check(smp_slot == 0, "R12 reset slot", 32'(smp_slot), 32'd0);
        cfg_pin_drive = 1; @(negedge clk);
        check(pin_sck_oe && pin_ws_oe, "R11 drive on", 32'({pin_sck_oe, pin_ws_oe}), 32'd3);
        cfg_pin_drive = 0; @(negedge clk);
        check(!pin_sck_oe && !pin_ws_oe, "R11 drive off", 32'({pin_sck_oe, pin_ws_oe}), 32'd0);

        for (int ci = 0; ci < 5; ci++)
            for (int a = 0; a < 2; a++)
                for (int p = 0; p < 2; p++)
                    for (int e = 0; e < 2; e++)
                        run_cfg(1, a[0], p[0], e[0], codes[ci], 0, 32, 2, cfgn++);
        for (int li = 0; li < 2; li++)
            for (int a = 0; a < 2; a++)
                for (int p = 0; p < 2; p++)
                    for (int e = 0; e < 2; e++)
                        run_cfg(0, a[0], p[0], e[0], 7, 0, li ? 32 : 24, 4, cfgn++);
        run_cfg(1, 1, 1, 1, 12, 1, 32, 2, cfgn++);
        run_cfg(0, 1, 1, 0, 9, 1, 24, 4, cfgn++);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule